// File: doc/BRIEF.md
# Zero-Latency Monitor Routing Mixer

This block gives every input of an 18-input audio front end (eight analog inputs, two S/PDIF inputs and eight ADAT inputs) a direct path to the two analog monitor outputs. Each input can be left off, sent to output 1, sent to output 2, or placed centred across both. The input never passes through the host to reach the monitor outputs.

Each input has two 32-bit control registers on a register write bus. Software writes a coded value into each one, and the block decodes the pair into a routing mode. Only a few value pairs are legal, and any other pair mutes the input.

On every frame strobe the block takes one 24-bit signed sample from each input. It adds up each input's contribution to the two outputs in a widened accumulator and clamps the results to 24 bits. One clock later it presents the two results together with a one-cycle valid pulse.

Top module: `monitor_router`

## Requirements
- R1: While reset is held, and after it is released, every channel is unrouted. Both monitor outputs read zero and the valid pulse is low until the first frame strobe.
- R2: The register pair of channel k sits at byte address 0x300 + 8k (left) and 0x300 + 8k + 4 (right). Channels 0–7 are analog, 8–9 are S/PDIF and 10–17 are ADAT. A write to an address that is not 4-byte aligned, or that lies outside 0x300–0x38F, changes nothing.
- R3: If both registers of a channel hold 0x00000000, that channel adds nothing to either output.
- R4: Left = 0x20000000 with right = 0x00000000 adds the full sample to output 1 only.
- R5: Left = 0x00000000 with right = 0x20000000 adds the full sample to output 2 only.
- R6: If both registers hold 0x18000000, the sample shifted right arithmetically by one bit is added to each output. The shift rounds toward minus infinity, so -1 stays -1 and -3 gives -2.
- R7: Any other register pair, including a pair where only one register is legal, leaves the channel unrouted.
- R8: The contributions of all channels are added without intermediate overflow. The sum is then clamped to the 24-bit signed range, 0x7FFFFF to 0x800000.
- R9: The outputs are updated on the clock edge that samples a frame strobe. The valid signal is high for exactly the following cycle. Between strobes the outputs hold their value, even while the inputs change.
- R10: The frame strobe uses the routing that was written before its own cycle. A register write in the same cycle as a strobe takes effect from the next strobe onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| frameStrobe | input | 1 | One-cycle pulse marking a new frame of samples |
| samplesIn | input | 432 | One 24-bit signed sample per channel, channel k in bits 24k+23:24k |
| monOut1 | output | 24 | Monitor output 1 |
| monOut2 | output | 24 | Monitor output 2 |
| outValid | output | 1 | Pulses high in the cycle after a frame strobe |

## Verification
The bench goes after the mixed register pairs, because a decoder that checks only one register of the pair would let a half-written channel leak onto an output. It drives negative odd samples in centre mode, where a divide that rounds toward zero would give -1 instead of -2. It drives several full-scale inputs of both signs at once: a design that clamps too narrowly, or not at all, would wrap to the opposite polarity. It also sends misaligned writes, out-of-range writes and writes in the same cycle as a strobe, since a loose address decoder would alias channels and a bypass on the registers would change a frame one strobe early.

// File: rtl/monrt_pkg.sv
package monrt_pkg;

  localparam logic [31:0] CODE_NONE   = 32'h0000_0000;
  localparam logic [31:0] CODE_CENTRE = 32'h1800_0000;
  localparam logic [31:0] CODE_ONE    = 32'h2000_0000;

  // What one control register holds after the write value is classified
  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_CENTRE = 2'd1,
    CLS_ONE    = 2'd2,
    CLS_OTHER  = 2'd3
  } codeClass_e;

  // Routing mode of one channel after the left/right pair is decoded
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_OUT1   = 2'd1,
    MODE_OUT2   = 2'd2,
    MODE_CENTRE = 2'd3
  } routeMode_e;

  // Strobes that the control side gives to the datapath
  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

  function automatic codeClass_e classify(input logic [31:0] value);
    case (value)
      CODE_NONE:   return CLS_NONE;
      CODE_CENTRE: return CLS_CENTRE;
      CODE_ONE:    return CLS_ONE;
      default:     return CLS_OTHER;
    endcase
  endfunction

  function automatic routeMode_e pairToMode(input codeClass_e leftCls,
                                            input codeClass_e rightCls);
    if (leftCls == CLS_ONE && rightCls == CLS_NONE)          return MODE_OUT1;
    else if (leftCls == CLS_NONE && rightCls == CLS_ONE)     return MODE_OUT2;
    else if (leftCls == CLS_CENTRE && rightCls == CLS_CENTRE) return MODE_CENTRE;
    else                                                     return MODE_OFF;
  endfunction

endpackage

// File: rtl/monrt_ctrl.sv
module monrt_ctrl
  import monrt_pkg::*;
#(
  parameter int NUM_CH    = 18,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h300
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWrData,
  input  logic                  frameStrobe,
  output ctrlStrobe_t           strobes,
  output logic [2*NUM_CH-1:0]   modeBus
);

  localparam int SPAN = NUM_CH * 8;
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [ADDR_W-1:0] offset;
  logic              addrHit;
  logic [CH_W-1:0]   chIdx;
  logic              rightSide;
  codeClass_e        wrClass;

  assign offset    = regAddr - ADDR_W'(BASE_ADDR);
  assign addrHit   = regWrEn
                   && (regAddr >= ADDR_W'(BASE_ADDR))
                   && (offset < ADDR_W'(SPAN))
                   && (offset[1:0] == 2'b00);
  assign chIdx     = offset[CH_W+2:3];
  assign rightSide = offset[2];
  assign wrClass   = classify(regWrData);

  assign strobes.capture = frameStrobe;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    codeClass_e leftCls, rightCls;
    logic       selThis;

    assign selThis = addrHit && (chIdx == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        leftCls  <= CLS_NONE;
        rightCls <= CLS_NONE;
      end else if (selThis) begin
        if (rightSide) rightCls <= wrClass;
        else           leftCls  <= wrClass;
      end
    end

    assign modeBus[2*g +: 2] = pairToMode(leftCls, rightCls);
  end

endmodule

// File: rtl/monrt_datapath.sv
module monrt_datapath
  import monrt_pkg::*;
#(
  parameter int NUM_CH   = 18,
  parameter int SAMPLE_W = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobes,
  input  logic [2*NUM_CH-1:0]          modeBus,
  input  logic [NUM_CH*SAMPLE_W-1:0]   samplesIn,
  output logic [SAMPLE_W-1:0]          monOut1,
  output logic [SAMPLE_W-1:0]          monOut2,
  output logic                         outValid
);

  localparam int ACC_W = SAMPLE_W + $clog2(NUM_CH) + 1;
  localparam logic signed [ACC_W-1:0] SAT_MAX = ACC_W'((1 << (SAMPLE_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_MIN = -ACC_W'(1 << (SAMPLE_W-1));

  logic signed [ACC_W-1:0] contrib1 [NUM_CH];
  logic signed [ACC_W-1:0] contrib2 [NUM_CH];
  logic signed [ACC_W-1:0] sum1, sum2;

  for (genvar g = 0; g < NUM_CH; g++) begin : gTap
    logic signed [SAMPLE_W-1:0] smp;
    logic signed [ACC_W-1:0]    full, half;
    routeMode_e                 mode;

    assign smp  = $signed(samplesIn[g*SAMPLE_W +: SAMPLE_W]);
    assign full = ACC_W'(smp);
    assign half = full >>> 1;
    assign mode = routeMode_e'(modeBus[2*g +: 2]);

    always_comb begin
      contrib1[g] = '0;
      contrib2[g] = '0;
      case (mode)
        MODE_OUT1:   contrib1[g] = full;
        MODE_OUT2:   contrib2[g] = full;
        MODE_CENTRE: begin
          contrib1[g] = half;
          contrib2[g] = half;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sum1 = '0;
    sum2 = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      sum1 = sum1 + contrib1[i];
      sum2 = sum2 + contrib2[i];
    end
  end

  function automatic logic [SAMPLE_W-1:0] clampTo(input logic signed [ACC_W-1:0] v);
    if (v > SAT_MAX)      return SAT_MAX[SAMPLE_W-1:0];
    else if (v < SAT_MIN) return SAT_MIN[SAMPLE_W-1:0];
    else                  return v[SAMPLE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      monOut1  <= '0;
      monOut2  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) begin
        monOut1 <= clampTo(sum1);
        monOut2 <= clampTo(sum2);
      end
    end
  end

endmodule

// File: rtl/monitor_router.sv
module monitor_router
  import monrt_pkg::*;
#(
  parameter int NUM_CH    = 18,
  parameter int SAMPLE_W  = 24,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h300
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [31:0]                 regWrData,
  input  logic                        frameStrobe,
  input  logic [NUM_CH*SAMPLE_W-1:0]  samplesIn,
  output logic [SAMPLE_W-1:0]         monOut1,
  output logic [SAMPLE_W-1:0]         monOut2,
  output logic                        outValid
);

  ctrlStrobe_t         strobes;
  logic [2*NUM_CH-1:0] modeBus;

  monrt_ctrl #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .frameStrobe(frameStrobe),
    .strobes    (strobes),
    .modeBus    (modeBus)
  );

  monrt_datapath #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .modeBus  (modeBus),
    .samplesIn(samplesIn),
    .monOut1  (monOut1),
    .monOut2  (monOut2),
    .outValid (outValid)
  );

endmodule

// File: rtl/monrt_checker.sv
module monrt_checker #(
  parameter int NUM_CH   = 18,
  parameter int SAMPLE_W = 24
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  frameStrobe,
  input logic [2*NUM_CH-1:0]   modeBus,
  input logic [SAMPLE_W-1:0]   monOut1,
  input logic [SAMPLE_W-1:0]   monOut2,
  input logic                  outValid
);

  logic feeds1, feeds2;

  // Mode codes: 0 off, 1 output 1, 2 output 2, 3 centred
  always_comb begin
    feeds1 = 1'b0;
    feeds2 = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (modeBus[2*i +: 2] == 2'd1 || modeBus[2*i +: 2] == 2'd3) feeds1 = 1'b1;
      if (modeBus[2*i +: 2] == 2'd2 || modeBus[2*i +: 2] == 2'd3) feeds2 = 1'b1;
    end
  end

  p_out1_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && !feeds1) |=> (monOut1 == '0));

  p_out2_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && !feeds2) |=> (monOut2 == '0));

  p_valid_after_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> outValid);

  p_valid_has_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(frameStrobe));

  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> ($stable(monOut1) && $stable(monOut2)));

endmodule

bind monitor_router monrt_checker #(
  .NUM_CH  (NUM_CH),
  .SAMPLE_W(SAMPLE_W)
) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .frameStrobe(frameStrobe),
  .modeBus    (modeBus),
  .monOut1    (monOut1),
  .monOut2    (monOut2),
  .outValid   (outValid)
);

// File: tb/monitor_router_test.sv
module monitor_router_test;

  localparam int NUM_CH = 18;
  localparam int SW     = 24;
  localparam int AW     = 12;
  localparam int VN     = 10;
  localparam logic [SW-1:0] BG = 24'h111111;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  regWrEn = 1'b0;
  logic [AW-1:0]         regAddr = '0;
  logic [31:0]           regWrData = '0;
  logic                  frameStrobe = 1'b0;
  logic [NUM_CH*SW-1:0]  samplesIn = '0;
  logic [SW-1:0]         monOut1, monOut2;
  logic                  outValid;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  monitor_router uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameStrobe(frameStrobe), .samplesIn(samplesIn),
    .monOut1(monOut1), .monOut2(monOut2), .outValid(outValid)
  );

  // Vector table: channel, left code, right code, sample, expected out1, expected out2
  localparam int          vCh [VN] = '{0, 1, 8, 9, 17, 10, 5, 17, 3, 12};
  localparam logic [31:0] vL  [VN] = '{32'h20000000, 32'h0, 32'h18000000, 32'h18000000,
                                       32'h20000000, 32'h18000000, 32'h0, 32'h0,
                                       32'h20000000, 32'h18000000};
  localparam logic [31:0] vR  [VN] = '{32'h0, 32'h20000000, 32'h18000000, 32'h18000000,
                                       32'h20000000, 32'h0, 32'h0, 32'h20000000,
                                       32'h18000000, 32'h18000000};
  localparam logic [23:0] vS  [VN] = '{24'h000100, 24'h7FFFFF, 24'h000101, 24'hFFFFFF,
                                       24'h345678, 24'h222222, 24'h400000, 24'h800000,
                                       24'h010203, 24'hFFFFFD};
  localparam logic [23:0] vE1 [VN] = '{24'h000100, 24'h0, 24'h000080, 24'hFFFFFF,
                                       24'h0, 24'h0, 24'h0, 24'h0, 24'h0, 24'hFFFFFE};
  localparam logic [23:0] vE2 [VN] = '{24'h0, 24'h7FFFFF, 24'h000080, 24'hFFFFFF,
                                       24'h0, 24'h0, 24'h0, 24'h800000, 24'h0, 24'hFFFFFE};
  string vReq [VN] = '{"R4", "R5", "R6", "R6", "R7", "R7", "R3", "R5", "R7", "R6"};

  task automatic check(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] regOf(input int ch, input bit right);
    return AW'('h300 + ch * 8 + (right ? 4 : 0));
  endfunction

  task automatic writeReg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setPair(input int ch, input logic [31:0] l, input logic [31:0] r);
    writeReg(regOf(ch, 1'b0), l);
    writeReg(regOf(ch, 1'b1), r);
  endtask

  // Pulse the strobe; on return the outputs carry the new frame (one edge later)
  task automatic strobe();
    @(negedge clk);
    frameStrobe = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b0;
  endtask

  task automatic fillAll(input logic [SW-1:0] v);
    for (int i = 0; i < NUM_CH; i++) samplesIn[i*SW +: SW] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    fillAll(BG);
    repeat (3) @(negedge clk);
    check("R1 out1 in reset", monOut1, 24'h0);
    check("R1 out2 in reset", monOut2, 24'h0);
    check("R1 valid in reset", {23'h0, outValid}, 24'h1 - 24'h1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {23'h0, outValid}, 24'h0);
    strobe();
    check("R1 unrouted after reset out1", monOut1, 24'h0);
    check("R1 unrouted after reset out2", monOut2, 24'h0);

    // Table walk
    for (int v = 0; v < VN; v++) begin
      fillAll(BG);
      samplesIn[vCh[v]*SW +: SW] = vS[v];
      setPair(vCh[v], vL[v], vR[v]);
      strobe();
      check({vReq[v], " out1 R2 map"}, monOut1, vE1[v]);
      check({vReq[v], " out2 R2 map"}, monOut2, vE2[v]);
      setPair(vCh[v], 32'h0, 32'h0);
    end

    // R9: valid pulse length and output hold
    fillAll(24'h0);
    samplesIn[0 +: SW] = 24'h000042;
    setPair(0, 32'h20000000, 32'h0);
    strobe();
    check("R9 valid high", {23'h0, outValid}, 24'h1);
    check("R9 out1 updated", monOut1, 24'h000042);
    samplesIn[0 +: SW] = 24'h000777;
    @(negedge clk);
    check("R9 valid low after one cycle", {23'h0, outValid}, 24'h0);
    @(negedge clk);
    check("R9 out1 held", monOut1, 24'h000042);

    // R10: write in the strobe cycle uses the old routing
    @(negedge clk);
    regWrEn = 1'b1; regAddr = regOf(0, 1'b0); regWrData = 32'h0; frameStrobe = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; frameStrobe = 1'b0;
    check("R10 old routing used", monOut1, 24'h000777);
    strobe();
    check("R10 new routing next frame", monOut1, 24'h0);

    // R8: positive clamp on out1
    fillAll(24'h0);
    for (int c = 0; c < 4; c++) begin
      samplesIn[c*SW +: SW] = 24'h7FFFFF;
      setPair(c, 32'h20000000, 32'h0);
    end
    strobe();
    check("R8 positive clamp", monOut1, 24'h7FFFFF);
    check("R8 other output clean", monOut2, 24'h0);
    // R8: negative clamp on out2
    for (int c = 0; c < 4; c++) begin
      samplesIn[c*SW +: SW] = 24'h800000;
      setPair(c, 32'h0, 32'h20000000);
    end
    strobe();
    check("R8 negative clamp", monOut2, 24'h800000);
    check("R8 out1 after moving", monOut1, 24'h0);
    // R8: plain sum of a direct and a centred channel
    for (int c = 0; c < 4; c++) setPair(c, 32'h0, 32'h0);
    samplesIn[0 +: SW]  = 24'h000010;
    samplesIn[SW +: SW] = 24'h000020;
    samplesIn[2*SW +: SW] = 24'h0;
    samplesIn[3*SW +: SW] = 24'h0;
    setPair(0, 32'h20000000, 32'h0);
    setPair(1, 32'h18000000, 32'h18000000);
    strobe();
    check("R8 sum out1", monOut1, 24'h000020);
    check("R8 sum out2", monOut2, 24'h000010);
    setPair(0, 32'h0, 32'h0);
    setPair(1, 32'h0, 32'h0);

    // R2: misaligned, out-of-range and below-base writes change nothing
    fillAll(24'h001000);
    writeReg(12'h301, 32'h20000000);
    writeReg(12'h390, 32'h20000000);
    writeReg(12'h2F8, 32'h20000000);
    writeReg(12'h306, 32'h20000000);
    strobe();
    check("R2 ignored writes out1", monOut1, 24'h0);
    check("R2 ignored writes out2", monOut2, 24'h0);
    // R2: last ADAT channel at top of window routes to out1
    setPair(17, 32'h20000000, 32'h0);
    strobe();
    check("R2 top channel out1", monOut1, 24'h001000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule